// File: doc/BRIEF.md
# Oversampled Serial Clock Edge Sampler

This block receives a slow serial link (a clock line and a data line) without ever using the external clock as a clock. Both lines are sampled as plain data by a fast internal clock, which should run at least about ten times the serial clock rate. The synchronized serial clock is compared with a copy of itself delayed by one fast cycle. A difference between the two is a low-to-high or a high-to-low transition. Each transition produces a one-cycle strobe in the fast domain.

The data line passes through a synchronizer of the same depth as the clock line, so the two stay aligned. The bit that is captured is the data sample taken at the fast-clock instant in which the clock transition is first seen. A parameter chooses whether rising or falling transitions capture data. Both strobes are always driven. The method suits low-rate links such as a slow SPI. It cannot follow a serial clock that runs near the system clock frequency.

Top module: `serclk_edge_sampler`

## Requirements
- R1: While rst_ni is low, rise_o, fall_o and bit_o are all 0.
- R2: A low-to-high change of sclk_i that is present at system clock edge k makes rise_o high after edge k+SYNC_STAGES (edge k+2 by default) and not before.
- R3: A high-to-low change of sclk_i that is present at edge k makes fall_o high after edge k+SYNC_STAGES, with the same latency as R2.
- R4: Each strobe is high for exactly one system clock cycle per transition, however long sclk_i then holds its level.
- R5: With CAPTURE = CAP_RISE (the default), bit_o takes the value of sdata_i sampled at the same clock edge as the rising sclk_i level. It updates in the same cycle that rise_o goes high.
- R6: bit_o holds its value between capture strobes. In CAP_RISE mode a falling transition does not change bit_o.
- R7: After reset is released, no strobe is reported for a level that sclk_i already had during reset or while the pipeline is still filling. With sclk_i held high through reset, rise_o stays 0.
- R8: rise_o and fall_o are never high in the same cycle. A serial clock that changes level every system cycle still yields exactly one strobe per transition.
- R9: With CAPTURE = CAP_FALL, bit_o takes the sdata_i sample aligned with each falling transition and updates together with fall_o. Rising transitions leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Asynchronous external serial clock, treated as data |
| sdata_i | input | 1 | Asynchronous external serial data |
| rise_o | output | 1 | One-cycle strobe on each rising serial clock transition |
| fall_o | output | 1 | One-cycle strobe on each falling serial clock transition |
| bit_o | output | 1 | Data bit captured on the selected edge, held until the next capture |

## Verification
A serial clock change that the system clock first samples at edge k reaches a strobe after edge k+2. Two edges of that delay come from the synchronizer and one from the output register. bit_o changes on that same edge. The bench drives inputs on falling system clock edges and samples on falling edges. Each directed task checks that the strobe is still low at the second falling edge after a change, high at the third, and low again at the fourth. A strobe that is early, late or too long therefore fails. The reset task and the edge-history task check over several cycles after release that no strobe appears at all.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
  typedef enum logic {
    CAP_RISE = 1'b0,
    CAP_FALL = 1'b1
  } cap_edge_e;
endpackage

// File: rtl/serclk_sync.sv
module serclk_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/serclk_edge.sv
module serclk_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_det_o,
  output logic fall_det_o,
  output logic rise_o,
  output logic fall_o
);
  // history is trusted once the sync chain and the delay flop hold post-reset samples
  localparam int unsigned PrimeCnt = SYNC_STAGES + 1;
  localparam int unsigned CntW     = $clog2(PrimeCnt + 1);

  logic            lvl_d_q;
  logic [CntW-1:0] prime_q;
  logic            primed;

  assign primed = (prime_q == CntW'(PrimeCnt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prime_q <= '0;
      lvl_d_q <= 1'b0;
    end else begin
      if (!primed) prime_q <= prime_q + 1'b1;
      lvl_d_q <= lvl_i;
    end
  end

  assign rise_det_o = primed &  lvl_i & ~lvl_d_q;
  assign fall_det_o = primed & ~lvl_i &  lvl_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= rise_det_o;
      fall_o <= fall_det_o;
    end
  end
endmodule

// File: rtl/serclk_capture.sv
module serclk_capture
  import serclk_pkg::*;
#(
  parameter cap_edge_e CAPTURE = CAP_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_det_i,
  input  logic fall_det_i,
  input  logic data_i,
  output logic bit_o
);
  logic take;

  if (CAPTURE == CAP_RISE) begin : g_rise
    assign take = rise_det_i;
  end else begin : g_fall
    assign take = fall_det_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bit_o <= 1'b0;
    else if (take) bit_o <= data_i;
  end
endmodule

// File: rtl/serclk_edge_sampler.sv
module serclk_edge_sampler
  import serclk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter cap_edge_e   CAPTURE     = CAP_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic rise_o,
  output logic fall_o,
  output logic bit_o
);
  // clock and data share one chain so their alignment is preserved
  logic [1:0] sync_q;
  logic       rise_det;
  logic       fall_det;

  serclk_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sdata_i, sclk_i}),
    .q_o    (sync_q)
  );

  serclk_edge #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (sync_q[0]),
    .rise_det_o (rise_det),
    .fall_det_o (fall_det),
    .rise_o     (rise_o),
    .fall_o     (fall_o)
  );

  serclk_capture #(
    .CAPTURE (CAPTURE)
  ) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_det_i (rise_det),
    .fall_det_i (fall_det),
    .data_i     (sync_q[1]),
    .bit_o      (bit_o)
  );
endmodule

// File: rtl/serclk_edge_sampler_chk.sv
module serclk_edge_sampler_chk
  import serclk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter cap_edge_e   CAPTURE     = CAP_RISE
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_i,
  input logic sdata_i,
  input logic rise_o,
  input logic fall_o,
  input logic bit_o
);
  localparam int unsigned Lat = SYNC_STAGES + 1;

  logic cap_stb;
  assign cap_stb = (CAPTURE == CAP_RISE) ? rise_o : fall_o;

  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!rise_o && !fall_o && !bit_o)
        else $error("outputs active during reset");
    end
  end

  assert_rise_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> ($past(sclk_i, Lat) && !$past(sclk_i, Lat + 1)));

  assert_fall_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!$past(sclk_i, Lat) && $past(sclk_i, Lat + 1)));

  assert_rise_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

  assert_fall_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);

  assert_bit_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_stb |-> (bit_o == $past(sdata_i, Lat)));

  assert_bit_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bit_o) |-> cap_stb);

  assert_no_overlap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

bind serclk_edge_sampler serclk_edge_sampler_chk #(
  .SYNC_STAGES (SYNC_STAGES),
  .CAPTURE     (CAPTURE)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sclk_i  (sclk_i),
  .sdata_i (sdata_i),
  .rise_o  (rise_o),
  .fall_o  (fall_o),
  .bit_o   (bit_o)
);

// File: tb/tb_serclk_edge_sampler.sv
module tb_serclk_edge_sampler;
  import serclk_pkg::*;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0;
  logic sdata = 1'b0;
  logic rise_r, fall_r, bit_r;
  logic rise_f, fall_f, bit_f;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serclk_edge_sampler #(.SYNC_STAGES(2), .CAPTURE(CAP_RISE)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata),
    .rise_o(rise_r), .fall_o(fall_r), .bit_o(bit_r)
  );

  serclk_edge_sampler #(.SYNC_STAGES(2), .CAPTURE(CAP_FALL)) dut_fall (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata),
    .rise_o(rise_f), .fall_o(fall_f), .bit_o(bit_f)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // SPI-like capture monitor
  bit   mon_on = 1'b0;
  logic [7:0] rx_rise, rx_fall;
  int   n_rise_cap, n_fall_cap;
  always @(negedge clk) begin
    if (mon_on) begin
      if (rise_r) begin rx_rise <= {rx_rise[6:0], bit_r}; n_rise_cap <= n_rise_cap + 1; end
      if (fall_f) begin rx_fall <= {rx_fall[6:0], bit_f}; n_fall_cap <= n_fall_cap + 1; end
    end
  end

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 rise_o in reset", rise_r, 0);
    chk("R1 fall_o in reset", fall_r, 0);
    chk("R1 bit_o in reset", bit_r, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 no strobe after idle reset", rise_r | fall_r, 0);
  endtask

  // expects sclk low on entry
  task automatic t_rise(input logic d);
    logic fall_bit;
    fall_bit = bit_f;
    @(negedge clk);
    sclk = 1'b1; sdata = d;
    repeat (2) @(negedge clk);
    chk("R2 rise_o not early", rise_r, 0);
    @(negedge clk);
    chk("R2 rise_o due", rise_r, 1);
    chk("R5 bit_o captured on rise", bit_r, d);
    chk("R8 fall_o quiet on rise", fall_r, 0);
    chk("R9 fall mode bit unchanged by rise", bit_f, fall_bit);
    @(negedge clk);
    chk("R4 rise_o single cycle", rise_r, 0);
    chk("R6 bit_o held after strobe", bit_r, d);
  endtask

  // expects sclk high on entry
  task automatic t_fall(input logic d);
    logic rise_bit;
    rise_bit = bit_r;
    @(negedge clk);
    sclk = 1'b0; sdata = d;
    repeat (2) @(negedge clk);
    chk("R3 fall_o not early", fall_r, 0);
    @(negedge clk);
    chk("R3 fall_o due", fall_r, 1);
    chk("R9 bit_o captured on fall", bit_f, d);
    chk("R6 rise mode bit unchanged by fall", bit_r, rise_bit);
    @(negedge clk);
    chk("R4 fall_o single cycle", fall_r, 0);
    chk("R6 rise mode bit still held", bit_r, rise_bit);
  endtask

  task automatic t_hold();
    int n = 0;
    @(negedge clk);
    sclk = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rise_r) n++;
    end
    chk("R4 one rise strobe for long high", n, 1);
  endtask

  // sclk high on entry; data changes with each falling edge
  task automatic t_spi(input logic [7:0] tx);
    n_rise_cap = 0; n_fall_cap = 0;
    rx_rise = '0; rx_fall = '0;
    mon_on = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      sclk = 1'b0; sdata = tx[i];
      repeat (5) @(negedge clk);
      sclk = 1'b1;
      repeat (5) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    mon_on = 1'b0;
    chk("R5 rise-capture count", n_rise_cap, 8);
    chk("R5 rise-capture byte", rx_rise, tx);
    chk("R9 fall-capture count", n_fall_cap, 8);
    chk("R9 fall-capture byte", rx_fall, tx);
  endtask

  // sclk low on entry
  task automatic t_toggle();
    int nr = 0, nf = 0, both = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (i < 8) sclk = ~sclk;
      if (rise_r) nr++;
      if (fall_r) nf++;
      if (rise_r && fall_r) both++;
    end
    chk("R8 rise count at full rate", nr, 4);
    chk("R8 fall count at full rate", nf, 4);
    chk("R8 no overlapping strobes", both, 0);
  endtask

  task automatic t_reset_high();
    int n = 0;
    @(negedge clk);
    rst_ni = 1'b0; sclk = 1'b1; sdata = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 strobes cleared by reset", rise_r | fall_r, 0);
    chk("R1 bit_o cleared by reset", bit_r, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (rise_r || fall_r) n++;
    end
    chk("R7 no false edge with sclk high", n, 0);
    chk("R7 bit_o not captured", bit_r, 0);
  endtask

  initial begin
    t_reset();
    t_rise(1'b1);
    t_fall(1'b0);
    t_rise(1'b0);
    t_fall(1'b1);
    t_hold();
    t_spi(8'hA5);
    t_spi(8'h3C);
    @(negedge clk); sclk = 1'b0; repeat (4) @(negedge clk);
    t_toggle();
    repeat (4) @(negedge clk);
    t_reset_high();
    t_fall(1'b1);
    t_rise(1'b1);
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end
endmodule